// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block owns the program counter of a 32-bit integer core and chooses the address fetched in the next cycle. Each cycle it receives a decoded control class (plain sequential instruction, conditional branch, PC-relative jump-and-link, or register-indirect jump-and-link), two register operands, a three-bit condition code, a sign-extended immediate and the destination register index. It evaluates the branch comparison itself and presents the current PC, the return address PC+4 with its write strobe, and a flag that marks a redirected fetch.

PC-relative offsets are counted in halfwords: the immediate is doubled before it is added to the PC. The register-indirect target is the base operand plus the immediate, with bit 0 forced low. A link aimed at register zero suppresses the write strobe, so the same instruction serves as a plain jump or a return. The PC is a single register updated on every clock edge; synchronous reset loads a parameterised vector.

Top module: `pcsteer_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC loads `RESET_VEC` (default 0x0000_1000), whatever the other inputs are.
- R2: With class 00 (sequential) the next PC is PC+4 modulo 2^32, and `takenFlag` and `linkWe` are low.
- R3: With class 01 (branch) and a true condition, the next PC is PC + (imm << 1) modulo 2^32. Condition codes: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal, each comparing `rs1Val` with `rs2Val`.
- R4: With class 01 and a false condition, or with the unused codes 010 and 011, the next PC is PC+4 and `takenFlag` is low.
- R5: With class 10 (jump-and-link) the next PC is PC + (imm << 1).
- R6: With class 11 (register jump-and-link) the next PC is (`rs1Val` + imm) with bit 0 cleared.
- R7: `linkVal` always equals the current PC+4, and `linkWe` is high for classes 10 and 11 when `rdIdx` is not zero.
- R8: For classes 10 and 11 with `rdIdx` equal to zero, `linkWe` stays low while the jump still takes place.
- R9: `takenFlag` is high exactly when the next PC is the jump or branch target, that is for classes 10 and 11 and for class 01 with a true condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrlClass | input | 2 | 00 sequential, 01 branch, 10 jump-and-link, 11 register jump-and-link |
| condCode | input | 3 | Branch condition selector |
| rs1Val | input | 32 | First register operand, base for register jumps |
| rs2Val | input | 32 | Second register operand |
| immVal | input | 32 | Sign-extended immediate |
| rdIdx | input | 5 | Destination register index of the link |
| pcOut | output | 32 | Current program counter |
| linkVal | output | 32 | Return address PC+4 |
| linkWe | output | 1 | Write strobe for the return address |
| takenFlag | output | 1 | Next fetch is redirected to a target |

## Verification
The hardest situation to reach is an operand pair on which the signed and unsigned orderings disagree, such as 0x8000_0000 against 1, because random operands seldom straddle the sign boundary while sitting on the equal boundary as well. The stimulus places these pairs under all six condition codes, adds equal operands and the two unused codes, and then drives long random runs with operands drawn from a small pool that holds the sign boundary values. Jumps to targets near 0xFFFF_FFFF exercise wrap-around, odd register targets test the bit-0 clear, and a reset asserted during a jump tests its priority.

// File: rtl/pcsteer_pkg.sv
package pcsteer_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_JAL    = 2'b10,
    CLS_JALR   = 2'b11
  } ctrl_class_e;

  localparam logic [2:0] CC_EQ  = 3'b000;
  localparam logic [2:0] CC_NE  = 3'b001;
  localparam logic [2:0] CC_LT  = 3'b100;
  localparam logic [2:0] CC_GE  = 3'b101;
  localparam logic [2:0] CC_LTU = 3'b110;
  localparam logic [2:0] CC_GEU = 3'b111;

  // Comparison results handed from datapath to control.
  typedef struct packed {
    logic isEq;
    logic isLtS;
    logic isLtU;
  } cmp_flags_t;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic takeRel;
    logic takeInd;
  } pc_strobe_t;

endpackage

// File: rtl/pcsteer_ctrl.sv
module pcsteer_ctrl
  import pcsteer_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [1:0]           ctrlClass,
  input  logic [2:0]           condCode,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  cmp_flags_t           cmpFlags,
  output pc_strobe_t           strobes,
  output logic                 linkWe,
  output logic                 takenFlag
);

  ctrl_class_e clsDec;
  logic        condHit;
  logic        isLink;

  assign clsDec = ctrl_class_e'(ctrlClass);

  always_comb begin
    unique case (condCode)
      CC_EQ:   condHit = cmpFlags.isEq;
      CC_NE:   condHit = !cmpFlags.isEq;
      CC_LT:   condHit = cmpFlags.isLtS;
      CC_GE:   condHit = !cmpFlags.isLtS;
      CC_LTU:  condHit = cmpFlags.isLtU;
      CC_GEU:  condHit = !cmpFlags.isLtU;
      default: condHit = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    isLink  = 1'b0;
    unique case (clsDec)
      CLS_BRANCH: strobes.takeRel = condHit;
      CLS_JAL: begin
        strobes.takeRel = 1'b1;
        isLink          = 1'b1;
      end
      CLS_JALR: begin
        strobes.takeInd = 1'b1;
        isLink          = 1'b1;
      end
      default: ;
    endcase
  end

  assign linkWe    = isLink && (rdIdx != '0);
  assign takenFlag = strobes.takeRel || strobes.takeInd;

endmodule

// File: rtl/pcsteer_dp.sv
module pcsteer_dp
  import pcsteer_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] immVal,
  input  pc_strobe_t      strobes,
  output cmp_flags_t      cmpFlags,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] linkVal
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] immScaled;
  logic [XLEN-1:0] relTarget;
  logic [XLEN-1:0] indSum;
  logic [XLEN-1:0] indTarget;
  logic [XLEN-1:0] pcNext;

  assign pcPlus4   = pcReg + INSN_BYTES;
  assign immScaled = {immVal[XLEN-2:0], 1'b0};
  assign relTarget = pcReg + immScaled;
  assign indSum    = rs1Val + immVal;
  assign indTarget = {indSum[XLEN-1:1], 1'b0};

  assign cmpFlags.isEq  = (rs1Val == rs2Val);
  assign cmpFlags.isLtS = ($signed(rs1Val) < $signed(rs2Val));
  assign cmpFlags.isLtU = (rs1Val < rs2Val);

  always_comb begin
    if (strobes.takeInd)      pcNext = indTarget;
    else if (strobes.takeRel) pcNext = relTarget;
    else                      pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= RESET_VEC;
    else     pcReg <= pcNext;
  end

  assign pcOut   = pcReg;
  assign linkVal = pcPlus4;

endmodule

// File: rtl/pcsteer_top.sv
module pcsteer_top
  import pcsteer_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              REG_IDX_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           ctrlClass,
  input  logic [2:0]           condCode,
  input  logic [XLEN-1:0]      rs1Val,
  input  logic [XLEN-1:0]      rs2Val,
  input  logic [XLEN-1:0]      immVal,
  input  logic [REG_IDX_W-1:0] rdIdx,
  output logic [XLEN-1:0]      pcOut,
  output logic [XLEN-1:0]      linkVal,
  output logic                 linkWe,
  output logic                 takenFlag
);

  cmp_flags_t cmpFlags;
  pc_strobe_t strobes;

  pcsteer_ctrl #(
    .REG_IDX_W(REG_IDX_W)
  ) ctrl_i (
    .ctrlClass(ctrlClass),
    .condCode (condCode),
    .rdIdx    (rdIdx),
    .cmpFlags (cmpFlags),
    .strobes  (strobes),
    .linkWe   (linkWe),
    .takenFlag(takenFlag)
  );

  pcsteer_dp #(
    .XLEN     (XLEN),
    .RESET_VEC(RESET_VEC)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .rs1Val  (rs1Val),
    .rs2Val  (rs2Val),
    .immVal  (immVal),
    .strobes (strobes),
    .cmpFlags(cmpFlags),
    .pcOut   (pcOut),
    .linkVal (linkVal)
  );

endmodule

// File: rtl/pcsteer_chk.sv
module pcsteer_chk #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           ctrlClass,
  input logic [XLEN-1:0]      rs1Val,
  input logic [XLEN-1:0]      immVal,
  input logic [REG_IDX_W-1:0] rdIdx,
  input logic [XLEN-1:0]      pcOut,
  input logic [XLEN-1:0]      linkVal,
  input logic                 linkWe,
  input logic                 takenFlag
);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 2'b00) |=> (pcOut == $past(pcOut) + XLEN'(4)));

  a_r4_not_taken_step: assert property (@(posedge clk) disable iff (rst)
    !takenFlag |=> (pcOut == $past(pcOut) + XLEN'(4)));

  a_r5_jal_target: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 2'b10) |=>
      (pcOut == $past(pcOut) + {$past(immVal[XLEN-2:0]), 1'b0}));

  a_r6_jalr_target: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 2'b11) |=>
      (pcOut == (($past(rs1Val) + $past(immVal)) & ~XLEN'(1))));

  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> (linkVal == pcOut + XLEN'(4)));

  a_r8_zero_dest: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass[1] && rdIdx == '0) |-> (!linkWe && takenFlag));

  a_r9_seq_no_flag: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 2'b00) |-> !takenFlag);

endmodule

bind pcsteer_top pcsteer_chk #(
  .XLEN     (XLEN),
  .REG_IDX_W(REG_IDX_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ctrlClass(ctrlClass),
  .rs1Val   (rs1Val),
  .immVal   (immVal),
  .rdIdx    (rdIdx),
  .pcOut    (pcOut),
  .linkVal  (linkVal),
  .linkWe   (linkWe),
  .takenFlag(takenFlag)
);

// File: tb/pcsteer_top_tb_top.sv
module pcsteer_top_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_VEC    = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ctrlClass = 2'b00;
  logic [2:0]  condCode = 3'b000;
  logic [31:0] rs1Val = '0;
  logic [31:0] rs2Val = '0;
  logic [31:0] immVal = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] pcOut;
  logic [31:0] linkVal;
  logic        linkWe;
  logic        takenFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] modelPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcsteer_top #(.RESET_VEC(RST_VEC)) dut_i (
    .clk(clk), .rst(rst), .ctrlClass(ctrlClass), .condCode(condCode),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .immVal(immVal), .rdIdx(rdIdx),
    .pcOut(pcOut), .linkVal(linkVal), .linkWe(linkWe), .takenFlag(takenFlag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit refCond(input logic [2:0] cc, input logic [31:0] a,
                                 input logic [31:0] b);
    int signed sa = int'(a);
    int signed sb = int'(b);
    case (cc)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return sa < sb;
      3'd5: return sa >= sb;
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  // One instruction: drive at the falling edge, check combinational outputs,
  // then check the PC one rising edge later.
  task automatic step(input logic [1:0] c, input logic [2:0] cc, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] im, input logic [4:0] rd,
                      input string req);
    bit expTaken;
    bit expWe;
    logic [31:0] expNext;
    ctrlClass = c; condCode = cc; rs1Val = a; rs2Val = b; immVal = im; rdIdx = rd;
    #1;
    case (c)
      2'b00: expTaken = 1'b0;
      2'b01: expTaken = refCond(cc, a, b);
      default: expTaken = 1'b1;
    endcase
    expWe = c[1] && (rd != 0);
    if (c == 2'b11)    expNext = (a + im) & 32'hFFFF_FFFE;
    else if (expTaken) expNext = modelPc + (im * 2);
    else               expNext = modelPc + 4;
    check(pcOut == modelPc, {req, " pc"}, pcOut, modelPc);
    check(linkVal == modelPc + 4, "R7 link value", linkVal, modelPc + 4);
    check(linkWe == expWe, (rd == 0) ? "R8 write strobe" : "R7 write strobe",
          32'(linkWe), 32'(expWe));
    check(takenFlag == expTaken, "R9 taken flag", 32'(takenFlag), 32'(expTaken));
    @(posedge clk);
    @(negedge clk);
    modelPc = expNext;
    check(pcOut == expNext, {req, " next pc"}, pcOut, expNext);
  endtask

  initial begin
    logic [31:0] pool [8];
    pool[0] = 32'h0000_0000; pool[1] = 32'h0000_0001; pool[2] = 32'h7FFF_FFFF;
    pool[3] = 32'h8000_0000; pool[4] = 32'hFFFF_FFFF; pool[5] = 32'h0000_1234;
    pool[6] = 32'hFFFF_FFFE; pool[7] = 32'h8000_0001;

    repeat (3) @(negedge clk);
    check(pcOut == RST_VEC, "R1 reset vector", pcOut, RST_VEC);
    rst = 1'b0;
    modelPc = RST_VEC;

    step(2'b00, 3'd0, 0, 0, 32'h40, 5'd3, "R2 sequential");
    step(2'b00, 3'd5, 5, 5, 32'hFFFF_FFF0, 5'd1, "R2 sequential");
    // Branch conditions on sign-boundary pairs
    step(2'b01, 3'd0, 32'h55, 32'h55, 32'h10, 5'd0, "R3 eq taken");
    step(2'b01, 3'd0, 32'h55, 32'h56, 32'h10, 5'd0, "R4 eq not taken");
    step(2'b01, 3'd1, 32'h1, 32'h2, 32'hFFFF_FFF8, 5'd0, "R3 ne taken");
    step(2'b01, 3'd1, 32'h9, 32'h9, 32'h8, 5'd0, "R4 ne not taken");
    step(2'b01, 3'd4, 32'h8000_0000, 32'h1, 32'h20, 5'd0, "R3 lt signed taken");
    step(2'b01, 3'd6, 32'h8000_0000, 32'h1, 32'h20, 5'd0, "R4 ltu not taken");
    step(2'b01, 3'd5, 32'h8000_0000, 32'h1, 32'h20, 5'd0, "R4 ge signed not taken");
    step(2'b01, 3'd7, 32'h8000_0000, 32'h1, 32'h30, 5'd0, "R3 geu taken");
    step(2'b01, 3'd5, 32'h7, 32'h7, 32'h4, 5'd0, "R3 ge equal taken");
    step(2'b01, 3'd6, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFC0, 5'd0, "R3 ltu taken");
    step(2'b01, 3'd2, 32'h1, 32'h1, 32'h40, 5'd0, "R4 unused code");
    step(2'b01, 3'd3, 32'h1, 32'h2, 32'h40, 5'd0, "R4 unused code");
    // Jumps
    step(2'b10, 3'd0, 0, 0, 32'h100, 5'd1, "R5 jal");
    step(2'b10, 3'd0, 0, 0, 32'hFFFF_FF00, 5'd0, "R5 R8 jal to x0");
    step(2'b11, 3'd0, 32'h0000_2001, 32'h0, 32'h0000_0004, 5'd5, "R6 jalr odd clear");
    step(2'b11, 3'd0, 32'h0000_3000, 32'h0, 32'hFFFF_FFFF, 5'd0, "R6 R8 jalr to x0");
    step(2'b11, 3'd0, 32'hFFFF_FFF8, 32'h0, 32'h0000_0004, 5'd2, "R6 jalr high");
    step(2'b00, 3'd0, 0, 0, 0, 5'd0, "R2 wrap");
    step(2'b00, 3'd0, 0, 0, 0, 5'd0, "R2 wrap");
    step(2'b10, 3'd0, 0, 0, 32'h0000_0010, 5'd4, "R5 jal wrap");

    // Reset during a jump takes priority
    ctrlClass = 2'b10; immVal = 32'h400; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(pcOut == RST_VEC, "R1 reset over jump", pcOut, RST_VEC);
    rst = 1'b0;
    modelPc = RST_VEC;

    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      logic [31:0] a, b, im;
      c  = 2'($urandom_range(0, 3));
      a  = ($urandom_range(0, 1) == 1) ? pool[$urandom_range(0, 7)] : $urandom;
      b  = ($urandom_range(0, 1) == 1) ? pool[$urandom_range(0, 7)] : $urandom;
      if ($urandom_range(0, 3) == 0) b = a;
      im = {{20{1'b0}}, 12'($urandom)};
      if ($urandom_range(0, 1) == 1) im = im | 32'hFFFF_F000;
      step(c, 3'($urandom), a, b, im, 5'($urandom), "R3 R9 random");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule